// File: doc/BRIEF.md
# Word-Split Load/Store Sequencer

This block sits beside the pipeline of a small real-time core and carries out its multi-byte loads and stores. The core hands over a byte address, a byte count of 1 to `MAX_BYTES` and a direction. The sequencer splits the transfer into beats, one for each aligned bus word the transfer touches, and drives them onto a local bus that is `BUS_BYTES` wide. Byte enables mark the lanes in use. On a store, the source bytes are moved onto the lanes they belong to. On a load, the returned lanes are gathered and rotated so that the byte at the start address becomes byte 0 of the result.

The cycle count is fixed and can be predicted. A load pays two cycles of overhead plus one cycle per beat. A store pays one cycle per beat and releases the core without waiting for any acknowledgement. A misaligned transfer that touches one more word pays one more beat. Each cycle in which the bus grant is withheld while a beat is presented stretches the transfer by one cycle. While `busy` is high the core stalls. `done` marks the first cycle after the transfer ends.

Top module: `lsq_seq`

## Requirements
- R1: A transfer of `count` bytes at address `a` issues `((a mod 4) + count + 3) / 4` beats (integer division). Beat k presents word address `(a >> 2) + k`, in ascending order, with one beat in flight at a time.
- R2: Without stalls, a load keeps `busy` high for `2 + beats` cycles. The first word is therefore in hand after 3 cycles, and each further word adds 1 cycle.
- R3: Without stalls, a store keeps `busy` high for exactly `beats` cycles. Every busy cycle presents one beat with `bus_we` high, and no acknowledgement is awaited.
- R4: Crossing a word boundary costs one beat. Two bytes at offset 2 take one beat and two bytes at offset 3 take two. A 16-byte load takes 6 cycles when aligned and 7 cycles at offset 1.
- R5: Each cycle with `bus_req` high and `bus_grant` low holds the current beat with the same address, enables and data, and adds one cycle to the transfer. `bus_grant` has no effect in any other cycle.
- R6: Bit l of `bus_be` in beat k is set exactly when the byte position `4k + l`, counted from the word holding the start address, lies in `[a mod 4, a mod 4 + count)`.
- R7: On a store, lane l of beat k carries byte `4k + l - (a mod 4)` of `req_wdata`, where byte j of `req_wdata` is bits `8j+7:8j`. Lanes whose enable is clear drive zero.
- R8: The bus returns `bus_rdata` in the cycle after a granted load beat. In the `done` cycle of a load, byte j of `rd_data` (bits `8j+7:8j`) equals the memory byte at `a + j` for j < count, and the bytes at j >= count are zero.
- R9: `done` is high for exactly one cycle. That cycle immediately follows the last busy cycle, and `busy` is low in it.
- R10: A request presented while `busy` is high is ignored and leaves the running transfer unchanged.
- R11: A request with `count` equal to 0 or greater than `MAX_BYTES` is ignored, and `busy` stays low.
- R12: While `rst` is high, and in the cycle after it, `busy`, `done` and `bus_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Transfer request, taken when idle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Start byte address |
| req_count | input | CNT_W | Byte count, 1 to MAX_BYTES |
| req_wdata | input | 8*MAX_BYTES | Store source bytes, byte 0 first |
| busy | output | 1 | Transfer in progress, stall the core |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rd_data | output | 8*MAX_BYTES | Rotated load result |
| bus_req | output | 1 | Beat presented this cycle |
| bus_we | output | 1 | Beat is a write |
| bus_addr | output | ADDR_W-log2(BUS_BYTES) | Word address of the beat |
| bus_be | output | BUS_BYTES | Lane enables |
| bus_wdata | output | 8*BUS_BYTES | Write lanes |
| bus_rdata | input | 8*BUS_BYTES | Read lanes, one cycle after a granted load beat |
| bus_grant | input | 1 | Bus granted this cycle |

## Verification
The bench uses the default parameters: a 32-byte staging buffer, a 4-byte bus and 16-bit addresses. With these it reaches the longest case, a 9-beat transfer of 32 bytes starting at a misaligned offset, and it covers all four lane offsets for both first and last beats. A behavioural model predicts every output on every cycle. Directed transfers check the fixed latencies, the one-beat and two-beat boundary pair and the rotated load result. A pseudo-random grant pattern puts stalls into setup, issue and drain cycles alike.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_ISSUE = 2'd2,
    ST_DRAIN = 2'd3
  } lsq_state_e;
endpackage

// File: rtl/lsq_beat_plan.sv
// Beat count and request legality, from start offset and byte count.
module lsq_beat_plan #(
  parameter int BUS_BYTES = 4,
  parameter int MAX_BYTES = 32,
  parameter int BEAT_W    = 4,
  localparam int OFF_W    = $clog2(BUS_BYTES),
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic [OFF_W-1:0]  off,
  input  logic [CNT_W-1:0]  count,
  output logic [BEAT_W-1:0] beats,
  output logic              count_ok
);
  localparam int SUM_W = CNT_W + OFF_W + 1;

  logic [SUM_W-1:0] span;

  assign span     = SUM_W'(off) + SUM_W'(count) + SUM_W'(BUS_BYTES - 1);
  assign beats    = BEAT_W'(span >> OFF_W);
  assign count_ok = (count != '0) && (count <= CNT_W'(MAX_BYTES));
endmodule

// File: rtl/lsq_lane_mask.sv
// Lane enables for one beat: lane is live if its byte position is covered.
module lsq_lane_mask #(
  parameter int BUS_BYTES = 4,
  parameter int MAX_BYTES = 32,
  parameter int BEAT_W    = 4,
  localparam int OFF_W    = $clog2(BUS_BYTES),
  localparam int CNT_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic [BEAT_W-1:0]    beat,
  input  logic [OFF_W-1:0]     off,
  input  logic [CNT_W-1:0]     count,
  output logic [BUS_BYTES-1:0] be
);
  localparam int POS_W = BEAT_W + OFF_W + 1;

  logic [POS_W-1:0] lo, hi;

  assign lo = POS_W'(off);
  assign hi = POS_W'(off) + POS_W'(count);

  for (genvar l = 0; l < BUS_BYTES; l++) begin : g_lane
    logic [POS_W-1:0] pos;
    assign pos   = {1'b0, beat, OFF_W'(l)};
    assign be[l] = (pos >= lo) && (pos < hi);
  end
endmodule

// File: rtl/lsq_read_gather.sv
// Word-indexed capture store (RAM-shaped) plus rotation to byte 0.
module lsq_read_gather #(
  parameter int BUS_BYTES = 4,
  parameter int MAX_BYTES = 32,
  parameter int MAX_BEATS = 9,
  parameter int BEAT_W    = 4,
  localparam int OFF_W    = $clog2(BUS_BYTES),
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int BUS_W    = 8 * BUS_BYTES,
  localparam int DATA_W   = 8 * MAX_BYTES
) (
  input  logic              clk,
  input  logic              cap_en,
  input  logic [BEAT_W-1:0] cap_idx,
  input  logic [BUS_W-1:0]  cap_data,
  input  logic [OFF_W-1:0]  off,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] rd_data
);
  localparam int RAW_W = MAX_BEATS * BUS_W;
  localparam int POS_W = $clog2(MAX_BEATS * BUS_BYTES);

  logic [BUS_W-1:0] raw_q [MAX_BEATS];
  logic [RAW_W-1:0] raw_flat;

  always_ff @(posedge clk) begin
    if (cap_en) raw_q[cap_idx] <= cap_data;
  end

  for (genvar b = 0; b < MAX_BEATS; b++) begin : g_flat
    assign raw_flat[b*BUS_W +: BUS_W] = raw_q[b];
  end

  for (genvar j = 0; j < MAX_BYTES; j++) begin : g_rot
    logic [POS_W-1:0] src;
    assign src = POS_W'(j) + POS_W'(off);
    assign rd_data[j*8 +: 8] = (CNT_W'(j) < count) ? raw_flat[src*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/lsq_seq.sv
// Multi-byte load/store sequencer with a fixed, alignment-driven latency.
module lsq_seq
  import lsq_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int MAX_BYTES = 32,
  parameter int BUS_BYTES = 4,
  localparam int CNT_W    = $clog2(MAX_BYTES + 1),
  localparam int OFF_W    = $clog2(BUS_BYTES),
  localparam int WADDR_W  = ADDR_W - OFF_W,
  localparam int BUS_W    = 8 * BUS_BYTES,
  localparam int DATA_W   = 8 * MAX_BYTES
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [CNT_W-1:0]     req_count,
  input  logic [DATA_W-1:0]    req_wdata,
  output logic                 busy,
  output logic                 done,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 bus_req,
  output logic                 bus_we,
  output logic [WADDR_W-1:0]   bus_addr,
  output logic [BUS_BYTES-1:0] bus_be,
  output logic [BUS_W-1:0]     bus_wdata,
  input  logic [BUS_W-1:0]     bus_rdata,
  input  logic                 bus_grant
);
  localparam int MAX_BEATS = (MAX_BYTES + 2 * BUS_BYTES - 2) / BUS_BYTES;
  localparam int BEAT_W    = $clog2(MAX_BEATS + 1);
  localparam int RAW_W     = MAX_BEATS * BUS_W;

  lsq_state_e          st_q;
  logic                is_wr_q, pend_q, done_q;
  logic [OFF_W-1:0]    off_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [BEAT_W-1:0]   nbeats_q, beat_q, cap_idx_q;
  logic [WADDR_W-1:0]  wbase_q;
  logic [RAW_W-1:0]    wraw_q;

  logic [BEAT_W-1:0]   plan_beats;
  logic                plan_ok;
  logic [DATA_W-1:0]   wmask;
  logic [RAW_W-1:0]    wshift;
  logic                last_beat;

  lsq_beat_plan #(.BUS_BYTES(BUS_BYTES), .MAX_BYTES(MAX_BYTES), .BEAT_W(BEAT_W)) u_plan (
    .off      (req_addr[OFF_W-1:0]),
    .count    (req_count),
    .beats    (plan_beats),
    .count_ok (plan_ok)
  );

  lsq_lane_mask #(.BUS_BYTES(BUS_BYTES), .MAX_BYTES(MAX_BYTES), .BEAT_W(BEAT_W)) u_mask (
    .beat  (beat_q),
    .off   (off_q),
    .count (cnt_q),
    .be    (bus_be)
  );

  lsq_read_gather #(
    .BUS_BYTES(BUS_BYTES), .MAX_BYTES(MAX_BYTES), .MAX_BEATS(MAX_BEATS), .BEAT_W(BEAT_W)
  ) u_gather (
    .clk      (clk),
    .cap_en   (pend_q),
    .cap_idx  (cap_idx_q),
    .cap_data (bus_rdata),
    .off      (off_q),
    .count    (cnt_q),
    .rd_data  (rd_data)
  );

  // Store bytes beyond the count are zeroed, then shifted onto their lanes.
  for (genvar j = 0; j < MAX_BYTES; j++) begin : g_wmask
    assign wmask[j*8 +: 8] = (CNT_W'(j) < req_count) ? req_wdata[j*8 +: 8] : 8'h00;
  end
  assign wshift = RAW_W'(wmask) << {req_addr[OFF_W-1:0], 3'b000};

  assign last_beat = (beat_q == nbeats_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      done_q    <= 1'b0;
      pend_q    <= 1'b0;
      is_wr_q   <= 1'b0;
      beat_q    <= '0;
      cap_idx_q <= '0;
      off_q     <= '0;
      cnt_q     <= '0;
      nbeats_q  <= '0;
      wbase_q   <= '0;
      wraw_q    <= '0;
    end else begin
      done_q <= 1'b0;
      pend_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (req_valid && plan_ok) begin
            is_wr_q  <= req_write;
            off_q    <= req_addr[OFF_W-1:0];
            cnt_q    <= req_count;
            nbeats_q <= plan_beats;
            wbase_q  <= req_addr[ADDR_W-1:OFF_W];
            wraw_q   <= wshift;
            beat_q   <= '0;
            st_q     <= req_write ? ST_ISSUE : ST_SETUP;
          end
        end
        ST_SETUP: st_q <= ST_ISSUE;
        ST_ISSUE: begin
          if (bus_grant) begin
            pend_q    <= !is_wr_q;
            cap_idx_q <= beat_q;
            if (last_beat) begin
              st_q   <= is_wr_q ? ST_IDLE : ST_DRAIN;
              done_q <= is_wr_q;
            end else begin
              beat_q <= beat_q + 1'b1;
            end
          end
        end
        ST_DRAIN: begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = done_q;
  assign bus_req   = (st_q == ST_ISSUE);
  assign bus_we    = bus_req & is_wr_q;
  assign bus_addr  = wbase_q + WADDR_W'(beat_q);
  assign bus_wdata = wraw_q[beat_q*BUS_W +: BUS_W];
endmodule

// File: rtl/lsq_seq_chk.sv
// Protocol checker, bound to every lsq_seq instance.
module lsq_seq_chk #(
  parameter int ADDR_W    = 16,
  parameter int BUS_BYTES = 4,
  localparam int WADDR_W  = ADDR_W - $clog2(BUS_BYTES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 busy,
  input logic                 done,
  input logic                 bus_req,
  input logic                 bus_grant,
  input logic [WADDR_W-1:0]   bus_addr,
  input logic [BUS_BYTES-1:0] bus_be
);
  assert_reset_quiet_R12: assert property (@(posedge clk)
    rst |=> (!busy && !done && !bus_req));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_busy_end_done_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);

  assert_beat_in_busy_R3: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> busy);

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (bus_req && !bus_grant) |=> (bus_req && $stable(bus_addr) && $stable(bus_be)));

  assert_lane_live_R6: assert property (@(posedge clk) disable iff (rst)
    bus_req |-> (bus_be != '0));
endmodule

bind lsq_seq lsq_seq_chk #(.ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES)) u_lsq_seq_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .done      (done),
  .bus_req   (bus_req),
  .bus_grant (bus_grant),
  .bus_addr  (bus_addr),
  .bus_be    (bus_be)
);

// File: tb/lsq_seq_bench.sv
module lsq_seq_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [15:0]  req_addr = '0;
  logic [5:0]   req_count = '0;
  logic [255:0] req_wdata = '0;
  logic         busy, done, bus_req, bus_we, bus_grant = 1'b1;
  logic [255:0] rd_data;
  logic [13:0]  bus_addr;
  logic [3:0]   bus_be;
  logic [31:0]  bus_wdata;
  logic [31:0]  bus_rdata = '0;

  int checks = 0, errors = 0;
  logic [15:0] lfsr = 16'hACE1;
  int seed = 5;

  always #2 clk = ~clk;

  lsq_seq u_lsq_seq (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_count(req_count), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data), .bus_req(bus_req),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_be(bus_be),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_grant(bus_grant)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Behavioural memory and reference model.
  logic [7:0] mem [256];
  int m_phase = 0, m_k = 0, m_nb = 0, m_off = 0, m_cnt = 0, m_addr = 0;
  bit m_wr = 0, m_done = 0;
  logic [7:0] m_wbuf [32];
  logic [7:0] m_rd [32];

  function automatic logic [31:0] memword(input int w);
    memword = {mem[(4*w+3) & 255], mem[(4*w+2) & 255], mem[(4*w+1) & 255], mem[(4*w) & 255]};
  endfunction

  always @(posedge clk) begin
    bit nd;
    if (rst) begin
      m_phase = 0;
      m_done  = 0;
    end else begin
      nd = 0;
      case (m_phase)
        0: if (req_valid && req_count >= 1 && req_count <= 32) begin
             m_wr = req_write; m_addr = int'(req_addr); m_cnt = int'(req_count);
             m_off = m_addr % 4; m_nb = (m_off + m_cnt + 3) / 4; m_k = 0;
             for (int j = 0; j < 32; j++) m_wbuf[j] = req_wdata[8*j +: 8];
             if (m_wr) for (int j = 0; j < m_cnt; j++) mem[(m_addr + j) & 255] = m_wbuf[j];
             m_phase = m_wr ? 2 : 1;
           end
        1: m_phase = 2;
        2: if (bus_grant) begin
             if (!m_wr) bus_rdata <= memword(m_addr / 4 + m_k);
             if (m_k == m_nb - 1) begin m_phase = m_wr ? 0 : 3; nd = m_wr; end
             else m_k++;
           end
        default: begin
             m_phase = 0; nd = 1;
             for (int j = 0; j < 32; j++) m_rd[j] = (j < m_cnt) ? mem[(m_addr + j) & 255] : 8'h00;
           end
      endcase
      m_done = nd;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      logic [3:0] ebe;
      logic [31:0] ewd;
      logic [255:0] erd;
      chk(busy === (m_phase != 0), "R2 R3 R5 busy", busy, m_phase != 0);
      chk(done === m_done, "R9 done", done, m_done);
      chk(bus_req === (m_phase == 2), "R1 bus_req", bus_req, m_phase == 2);
      if (m_phase == 2) begin
        for (int l = 0; l < 4; l++) begin
          int p;
          p = 4 * m_k + l;
          ebe[l] = (p >= m_off) && (p < m_off + m_cnt);
          ewd[8*l +: 8] = ebe[l] ? m_wbuf[p - m_off] : 8'h00;
        end
        chk(bus_addr === 14'(m_addr / 4 + m_k), "R1 word address", bus_addr, 14'(m_addr / 4 + m_k));
        chk(bus_be === ebe, "R6 lane enables", bus_be, ebe);
        chk(bus_we === m_wr, "R3 write strobe", bus_we, m_wr);
        if (m_wr) chk(bus_wdata === ewd, "R7 write lanes", bus_wdata, ewd);
      end
      if (m_done && !m_wr) begin
        for (int j = 0; j < 32; j++) erd[8*j +: 8] = m_rd[j];
        chk(rd_data === erd, "R8 load result", rd_data, erd);
      end
    end
  end

  // One transfer; latency measured at the ports and held against the rule.
  task automatic xfer(input bit wr, input int addr, input int cnt, input bit stall,
                      input bit inject, input string tag);
    int beats, lat, stalls, exp;
    beats = (addr % 4 + cnt + 3) / 4;
    req_valid = 1; req_write = wr; req_addr = 16'(addr); req_count = 6'(cnt);
    for (int j = 0; j < 32; j++) req_wdata[8*j +: 8] = 8'(seed + 29 * j);
    seed += 17;
    bus_grant = 1;
    @(negedge clk);
    req_valid = 0;
    lat = 0; stalls = 0;
    for (int i = 0; i < 300; i++) begin
      if (!busy) break;
      lat++;
      if (inject && lat == 2) begin
        req_valid = 1; req_write = !wr; req_addr = 16'(addr + 40); req_count = 6'd8;
      end else req_valid = 0;
      if (stall) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        bus_grant = lfsr[0] | lfsr[5];
      end
      if (bus_req && !bus_grant) stalls++;
      @(negedge clk);
    end
    req_valid = 0;
    bus_grant = 1;
    exp = (wr ? 0 : 2) + beats + stalls;
    chk(lat == exp, tag, lat, exp);
    chk(done === 1'b1, "R9 done after last busy cycle", done, 1);
    @(negedge clk);
    chk(done === 1'b0, "R9 done single cycle", done, 0);
    chk(busy === 1'b0, "R10 no stray accept", busy, 0);
  endtask

  task automatic rejected(input int cnt);
    req_valid = 1; req_write = 0; req_addr = 16'h0010; req_count = 6'(cnt);
    @(negedge clk);
    req_valid = 0;
    chk(busy === 1'b0, "R11 bad count ignored", busy, 0);
    @(negedge clk);
    chk(busy === 1'b0 && bus_req === 1'b0, "R11 still idle", busy, 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 11);
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && bus_req === 1'b0, "R12 reset outputs",
        {busy, done, bus_req}, 0);
    rst = 0;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && bus_req === 1'b0, "R12 after reset",
        {busy, done, bus_req}, 0);

    xfer(1, 'h10, 4, 0, 0, "R3 aligned word store");
    xfer(0, 'h10, 4, 0, 0, "R2 aligned word load");
    xfer(0, 'h20, 16, 0, 0, "R4 R2 aligned 16-byte load");
    xfer(0, 'h21, 16, 0, 0, "R4 misaligned 16-byte load");
    xfer(1, 'h32, 2, 0, 0, "R4 two bytes at offset 2");
    xfer(1, 'h37, 2, 0, 0, "R4 two bytes at offset 3");
    xfer(0, 'h37, 2, 0, 0, "R4 R8 load across boundary");
    xfer(1, 'h45, 32, 0, 0, "R1 R7 full store offset 1");
    xfer(0, 'h45, 32, 0, 0, "R1 R8 full load offset 1");
    xfer(0, 'h07, 1, 0, 0, "R6 single byte lane 3");
    xfer(1, 'h9e, 13, 0, 0, "R6 R7 partial lanes");
    xfer(0, 'h9e, 13, 0, 0, "R8 partial result zero fill");
    xfer(0, 'h60, 20, 0, 1, "R10 request during load");
    xfer(1, 'h63, 9, 0, 1, "R10 request during store");
    rejected(0);
    rejected(33);
    for (int t = 0; t < 12; t++)
      xfer(t[0], 8 + 11 * t, 1 + (t * 7) % 32, 1, 0, "R5 stalled transfer");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule